// File: doc/BRIEF.md
# Interleaved NOR Flash Command Responder

This block is the command front end of a parallel NOR flash array made of N identical devices side by side on one wide data bus. It watches bus writes for the three-write unlock-and-command sequence and for single-write commands, and keeps track of the array mode: plain array read, identification (autoselect), or status. A command counts only when every device lane on the bus carries the same code. Writes aimed at one lane are not supported and are treated as a broken sequence.

On reads the block either passes the memory port data through unchanged or returns an identification or status value, copied into every lane. Each lane is (bus bytes / N) × 8 bits wide. Command addresses are device word addresses, which are the byte address divided by the lane width in bytes. Program and erase timing, sector protection, suspend and resume, and boot blocks are not part of this block. The status mode is a stub: it returns a ready value whose bit 6 toggles on each read.

Top module: `ilv_flash_cmd`

## Requirements
- R1: The interleave count parameter `ILV_CFG` sets N, and a value of 0 is treated as 1. The lane width is `BUS_BYTES`/N × 8 bits.
- R2: A command address is the byte address `addr_i` shifted right by log2(lane bytes). The result is compared against the word-address parameters `UNLOCK0` (default 0x555) and `UNLOCK1` (default 0x2AA).
- R3: Three consecutive writes enter autoselect mode: 0xAA at `UNLOCK0`, then 0x55 at `UNLOCK1`, then 0x90 at `UNLOCK0`. The new mode is visible on reads from the next cycle on. A write that validly advances the sequence leaves the current mode unchanged.
- R4: A command code is recognised only when every lane holds the same value and that value equals the 8-bit code zero-extended to the lane width. A write whose lanes differ counts as a breaking write (see R10).
- R5: In autoselect mode the offset is the low 8 bits of the word address. Offset 0 returns `MFR_ID` and offset 1 returns `DEV_ID`.
- R6: In autoselect mode, offset 2 returns 0 (all sectors unprotected). Every other offset returns array data.
- R7: Identification and status results are replicated into every lane. For example, ID 0x0001 with 8 bus bytes and N=4 reads as 0x0001000100010001.
- R8: A uniform write of 0x70 with no sequence in progress enters status mode and loads the per-lane status value 0x80.
- R9: In status mode, each read cycle without a write in the same cycle inverts bit 6 of the status value. Consecutive reads therefore alternate between 0x80 and 0xC0.
- R10: A uniform 0xF0 write, or any write that does not advance the sequence and is not R8's command, returns the block to array-read mode and clears the sequence.
- R11: In array-read mode, `rdata_o` equals `mem_rdata_i` with no lane replication.
- R12: After reset the block is in array-read mode with the sequence cleared and the status value at 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Bus write strobe, one write per cycle |
| rd_i | input | 1 | Bus read strobe, one read per cycle |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | BUS_BYTES*8 | Write data, all lanes |
| mem_rdata_i | input | BUS_BYTES*8 | Array data from the memory port for `addr_i` |
| rdata_o | output | BUS_BYTES*8 | Read data, combinational from mode, address and memory data |

## Verification
`rdata_o` is combinational: a read result is due in the same cycle as its address. A command write changes the mode at the clock edge that captures it, so the mode is first visible in the cycle after the write. A status read inverts bit 6 at the edge that ends the read cycle. The bench drives each input at a falling edge and samples 1 ns later. Every result is therefore read after the edge that should have produced it and before the next edge can change it. Autoselect offsets, lane-mismatch positions and status read runs are swept exhaustively, with the expected words built by arithmetic lane replication.

// File: rtl/ilv_flash_pkg.sv
package ilv_flash_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY   = 2'd0,
    MODE_AUTOSEL = 2'd1,
    MODE_STATUS  = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_GOT_AA = 2'd1,
    SEQ_GOT_55 = 2'd2
  } seq_e;

  localparam logic [7:0] CODE_UNLK_A   = 8'hAA;
  localparam logic [7:0] CODE_UNLK_B   = 8'h55;
  localparam logic [7:0] CODE_AUTOSEL  = 8'h90;
  localparam logic [7:0] CODE_STATUS   = 8'h70;
  localparam logic [7:0] STAT_INIT     = 8'h80;
  localparam logic [7:0] STAT_TOGGLE   = 8'h40;
endpackage

// File: rtl/ilv_lane_cmp.sv
module ilv_lane_cmp #(
  parameter int LANES  = 4,
  parameter int LANE_W = 16,
  localparam int BUS_W = LANES * LANE_W
) (
  input  logic [BUS_W-1:0]  wdata_i,
  output logic              uniform_o,
  output logic [LANE_W-1:0] lane0_o
);
  logic [LANES-1:0] eq;

  assign eq[0] = 1'b1;
  for (genvar gi = 1; gi < LANES; gi++) begin : g_lane
    assign eq[gi] = (wdata_i[gi*LANE_W +: LANE_W] == wdata_i[LANE_W-1:0]);
  end

  assign uniform_o = &eq;
  assign lane0_o   = wdata_i[LANE_W-1:0];
endmodule

// File: rtl/ilv_cmd_fsm.sv
module ilv_cmd_fsm
  import ilv_flash_pkg::*;
#(
  parameter int          WA_W    = 15,
  parameter int          LANE_W  = 16,
  parameter logic [15:0] UNLOCK0 = 16'h0555,
  parameter logic [15:0] UNLOCK1 = 16'h02AA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              uniform_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [WA_W-1:0]   waddr_i,
  output mode_e             mode_o,
  output logic [7:0]        stat_o
);
  localparam logic [WA_W-1:0] U0 = WA_W'(UNLOCK0);
  localparam logic [WA_W-1:0] U1 = WA_W'(UNLOCK1);

  mode_e      mode_q, mode_d;
  seq_e       seq_q, seq_d;
  logic [7:0] stat_q, stat_d;

  function automatic logic is_code(input logic [LANE_W-1:0] v, input logic [7:0] c);
    return v == LANE_W'(c);
  endfunction

  always_comb begin
    mode_d = mode_q;
    seq_d  = seq_q;
    stat_d = stat_q;
    if (wr_i) begin
      seq_d  = SEQ_IDLE;
      mode_d = MODE_ARRAY;  // default: sequence broken
      if (uniform_i) begin
        unique case (seq_q)
          SEQ_IDLE: begin
            if (is_code(lane_i, CODE_UNLK_A) && waddr_i == U0) begin
              seq_d  = SEQ_GOT_AA;
              mode_d = mode_q;
            end else if (is_code(lane_i, CODE_STATUS)) begin
              mode_d = MODE_STATUS;
              stat_d = STAT_INIT;
            end
          end
          SEQ_GOT_AA: begin
            if (is_code(lane_i, CODE_UNLK_B) && waddr_i == U1) begin
              seq_d  = SEQ_GOT_55;
              mode_d = mode_q;
            end
          end
          SEQ_GOT_55: begin
            if (is_code(lane_i, CODE_AUTOSEL) && waddr_i == U0) mode_d = MODE_AUTOSEL;
          end
          default: ;
        endcase
      end
    end else if (rd_i && mode_q == MODE_STATUS) begin
      stat_d = stat_q ^ STAT_TOGGLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_ARRAY;
      seq_q  <= SEQ_IDLE;
      stat_q <= STAT_INIT;
    end else begin
      mode_q <= mode_d;
      seq_q  <= seq_d;
      stat_q <= stat_d;
    end
  end

  assign mode_o = mode_q;
  assign stat_o = stat_q;

  // R4 / R10: a lane-mismatched write always drops to array read
  assert_mismatch_breaks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !uniform_i) |=> (mode_q == MODE_ARRAY && seq_q == SEQ_IDLE));

  // R3: completing the sequence enters autoselect
  assert_autosel_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && uniform_i && seq_q == SEQ_GOT_55 && is_code(lane_i, CODE_AUTOSEL) && waddr_i == U0)
    |=> mode_q == MODE_AUTOSEL);

  // R10: reset command returns to array read
  assert_reset_cmd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && uniform_i && is_code(lane_i, 8'hF0)) |=> (mode_q == MODE_ARRAY && seq_q == SEQ_IDLE));

  // R9: status reads alternate bit 6
  assert_status_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && mode_q == MODE_STATUS) |=> stat_q == ($past(stat_q) ^ STAT_TOGGLE));
endmodule

// File: rtl/ilv_rd_mux.sv
module ilv_rd_mux
  import ilv_flash_pkg::*;
#(
  parameter int          LANES  = 4,
  parameter int          LANE_W = 16,
  parameter logic [15:0] MFR_ID = 16'h0001,
  parameter logic [15:0] DEV_ID = 16'h227E,
  localparam int         BUS_W  = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic [7:0]       off_i,
  input  logic [7:0]       stat_i,
  input  logic [BUS_W-1:0] mem_rdata_i,
  output logic [BUS_W-1:0] rdata_o
);
  logic [LANE_W-1:0] lane_val;
  logic              use_rep;
  logic [BUS_W-1:0]  rep;

  always_comb begin
    lane_val = '0;
    use_rep  = 1'b0;
    unique case (mode_i)
      MODE_AUTOSEL: begin
        if (off_i == 8'd0) begin
          lane_val = LANE_W'(MFR_ID);
          use_rep  = 1'b1;
        end else if (off_i == 8'd1) begin
          lane_val = LANE_W'(DEV_ID);
          use_rep  = 1'b1;
        end else if (off_i == 8'd2) begin
          use_rep  = 1'b1;  // no sector protected
        end
      end
      MODE_STATUS: begin
        lane_val = LANE_W'(stat_i);
        use_rep  = 1'b1;
      end
      default: ;
    endcase
  end

  for (genvar gi = 0; gi < LANES; gi++) begin : g_rep
    assign rep[gi*LANE_W +: LANE_W] = lane_val;
  end

  assign rdata_o = use_rep ? rep : mem_rdata_i;

  function automatic logic lanes_equal(input logic [BUS_W-1:0] v);
    for (int i = 1; i < LANES; i++)
      if (v[i*LANE_W +: LANE_W] != v[LANE_W-1:0]) return 1'b0;
    return 1'b1;
  endfunction

  // R7: status results are identical in every lane
  assert_status_replicated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STATUS) |-> lanes_equal(rdata_o));
endmodule

// File: rtl/ilv_flash_cmd.sv
module ilv_flash_cmd
  import ilv_flash_pkg::*;
#(
  parameter int          BUS_BYTES = 8,
  parameter int          ILV_CFG   = 4,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] UNLOCK0   = 16'h0555,
  parameter logic [15:0] UNLOCK1   = 16'h02AA,
  parameter logic [15:0] MFR_ID    = 16'h0001,
  parameter logic [15:0] DEV_ID    = 16'h227E,
  localparam int         BUS_W     = BUS_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [BUS_W-1:0]  mem_rdata_i,
  output logic [BUS_W-1:0]  rdata_o
);
  localparam int LANES      = (ILV_CFG == 0) ? 1 : ILV_CFG;
  localparam int LANE_BYTES = BUS_BYTES / LANES;
  localparam int LANE_W     = LANE_BYTES * 8;
  localparam int SHIFT      = $clog2(LANE_BYTES);
  localparam int WA_W       = ADDR_W - SHIFT;

  logic [WA_W-1:0]   waddr;
  logic              uniform;
  logic [LANE_W-1:0] lane0;
  mode_e             mode;
  logic [7:0]        stat;
  logic              unused_addr;

  assign waddr       = addr_i[ADDR_W-1:SHIFT];
  assign unused_addr = ^addr_i;

  ilv_lane_cmp #(.LANES(LANES), .LANE_W(LANE_W)) u_cmp (
    .wdata_i   (wdata_i),
    .uniform_o (uniform),
    .lane0_o   (lane0)
  );

  ilv_cmd_fsm #(.WA_W(WA_W), .LANE_W(LANE_W), .UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .uniform_i (uniform),
    .lane_i    (lane0),
    .waddr_i   (waddr),
    .mode_o    (mode),
    .stat_o    (stat)
  );

  ilv_rd_mux #(.LANES(LANES), .LANE_W(LANE_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .off_i       (waddr[7:0]),
    .stat_i      (stat),
    .mem_rdata_i (mem_rdata_i),
    .rdata_o     (rdata_o)
  );

  // R11: array mode is a pure pass-through
  assert_array_passthru_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_ARRAY) |-> rdata_o == mem_rdata_i);
endmodule

// File: tb/ilv_flash_cmd_tb.sv
module ilv_flash_cmd_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] mem_rdata, rdata;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  // single-lane variant, interleave 0 -> 1
  logic        z_wr = 1'b0, z_rd = 1'b0;
  logic [15:0] z_addr = '0, z_wdata = '0, z_mem, z_rdata;

  localparam logic [15:0] U0B = 16'h0AAA;  // word 0x555 * 2 bytes
  localparam logic [15:0] U1B = 16'h0554;  // word 0x2AA * 2 bytes

  always #2.5 clk = ~clk;

  function automatic logic [63:0] mem_f(input logic [15:0] a);
    return {a, a ^ 16'hFFFF, a ^ 16'h5A5A, a + 16'h1234};
  endfunction

  function automatic logic [63:0] rep4(input logic [15:0] v);
    logic [63:0] r = '0;
    for (int i = 0; i < 4; i++) r = r | (64'(v) << (16 * i));
    return r;
  endfunction

  assign mem_rdata = mem_f(addr);
  assign z_mem     = z_addr ^ 16'hC3C3;

  ilv_flash_cmd u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr_en), .rd_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .mem_rdata_i(mem_rdata), .rdata_o(rdata));

  ilv_flash_cmd #(.BUS_BYTES(2), .ILV_CFG(0)) u_dut_z (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(z_wr), .rd_i(z_rd), .addr_i(z_addr),
    .wdata_i(z_wdata), .mem_rdata_i(z_mem), .rdata_o(z_rdata));

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_c(input logic [15:0] a, input logic [7:0] c);
    wr(a, rep4({8'h00, c}));
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 check(rdata, exp, tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic enter_autosel();
    wr_c(U0B, 8'hAA); wr_c(U1B, 8'h55); wr_c(U0B, 8'h90);
  endtask

  task automatic zwr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); z_addr = a; z_wdata = d; z_wr = 1'b1;
    @(negedge clk); z_wr = 1'b0;
  endtask

  task automatic zrd(input logic [15:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); z_addr = a; z_rd = 1'b1;
    #1 check(64'(z_rdata), 64'(exp), tag);
    @(negedge clk); z_rd = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    addr = 16'h0010;
    #1 check(rdata, mem_f(16'h0010), "R12 reset state array read");
    rst_n = 1'b1;

    // R11: pass-through sweep
    for (int i = 0; i < 16; i++) rd_chk(16'(i * 8), mem_f(16'(i * 8)), "R11 array pass-through");

    // R3/R5/R6/R7: autoselect offsets swept
    enter_autosel();
    for (int off = 0; off < 8; off++) begin
      logic [63:0] e;
      e = (off == 0) ? rep4(16'h0001) : (off == 1) ? rep4(16'h227E) :
          (off == 2) ? 64'h0 : mem_f(16'(off * 2));
      rd_chk(16'(off * 2), e, "R3 R5 R6 R7 autoselect offset");
    end
    rd_chk(16'h0202, rep4(16'h227E), "R5 offset from low address byte");
    rd_chk(16'h0200, rep4(16'h0001), "R7 replicated manufacturer id");
    // a valid partial sequence keeps autoselect
    wr_c(U0B, 8'hAA);
    rd_chk(16'h0000, rep4(16'h0001), "R3 advancing write keeps mode");

    // R10: reset command
    wr_c(16'h0000, 8'hF0);
    rd_chk(16'h0000, mem_f(16'h0000), "R10 F0 returns to array");

    // R2: unscaled byte addresses do not match
    wr_c(16'h0555, 8'hAA); wr_c(16'h02AA, 8'h55); wr_c(16'h0555, 8'h90);
    rd_chk(16'h0000, mem_f(16'h0000), "R2 address scaling");

    // R4: one lane differing at each position breaks the sequence
    for (int k = 0; k < 4; k++) begin
      logic [63:0] d;
      d = rep4(16'h00AA);
      d[k*16 +: 16] = 16'h00AB;
      wr(U0B, d); wr_c(U1B, 8'h55); wr_c(U0B, 8'h90);
      rd_chk(16'h0000, mem_f(16'h0000), "R4 lane mismatch");
    end
    enter_autosel();
    begin
      logic [63:0] d;
      d = rep4(16'h00F0);
      d[47:32] = 16'h00F1;
      wr(16'h0000, d);
    end
    rd_chk(16'h0000, mem_f(16'h0000), "R4 mismatched write leaves autoselect");

    // R10: mid-sequence break
    wr_c(U0B, 8'hAA); wr_c(U0B, 8'h55); wr_c(U0B, 8'h90);
    rd_chk(16'h0000, mem_f(16'h0000), "R10 broken sequence");

    // R8/R9: status mode alternation
    wr_c(16'h0000, 8'h70);
    for (int i = 0; i < 6; i++)
      rd_chk(16'h0000, rep4((i % 2 == 0) ? 16'h0080 : 16'h00C0), "R8 R9 status toggle");
    wr_c(16'h0000, 8'h70);
    rd_chk(16'h0000, rep4(16'h0080), "R8 status re-entry");
    wr_c(16'h0000, 8'hF0);
    rd_chk(16'h0000, mem_f(16'h0000), "R10 exit status");

    // R12: reset from autoselect
    enter_autosel();
    rd_chk(16'h0000, rep4(16'h0001), "R3 autoselect before reset");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_chk(16'h0000, mem_f(16'h0000), "R12 reset clears mode");

    // R1: interleave 0 behaves as 1, one 16-bit lane
    zwr(U0B, 16'h00AA); zwr(U1B, 16'h0055); zwr(U0B, 16'h0090);
    zrd(16'h0000, 16'h0001, "R1 single lane manufacturer");
    zrd(16'h0002, 16'h227E, "R1 single lane device");
    zrd(16'h0006, 16'h0006 ^ 16'hC3C3, "R1 single lane array offset");

    summary();
  end
endmodule